// File: doc/BRIEF.md
# System Clock Ratio Bank

This block derives eleven system clock outputs from a single fast source clock. Each output is a registered divider that can be driven out as a one-cycle enable pulse per period or as a clock-style level. Eight outputs have hard-wired ratios. The remaining three take ratios from software:

- the emulation-rate output (output 2),
- the trace-rate output (output 5),
- the slow system output (output 8).

Software writes a new ratio into a shadow register. Each write is checked against the legal range for that output and against the rule that the slow output is never faster than any other output. A write that fails a check is dropped and raises a sticky error flag. The shadow ratios take effect only when software issues a realign command. After a short settle delay, the command loads every shadow ratio and restarts all eleven counters on the same source cycle, so all outputs leave the realignment in phase. Outputs 2 and 5 can each be stopped by software. Their counters keep running while they are stopped, so they stay in phase.

Software sees a simple write port. Addresses 1 to 11 select the ratio of the output with the same number. Address 12 holds the gate bits. Address 13 issues the realign command.

Top module: `clk_ratio_bank`

## Requirements
- R1: After reset the pulse period, in source cycles, of outputs 1 to 11 is 1, 3, 2, 3, 5, 64, 6, 64, 12, 3, 6. Output bit k-1 of `sysPulse` and `sysClk` carries output k. While reset is held, all pulses, `goBusy` and `cfgErr` are 0.
- R2: Writes to the ratio addresses of fixed outputs (addresses 1, 3, 4, 6, 7, 9, 10, 11) have no effect on their periods, even after a realign.
- R3: Address 2 accepts ratios from 1 to 32. A value outside that range is dropped, the old ratio stays, and `cfgErr[0]` is set.
- R4: Address 5 accepts ratios from R5_MIN to R5_MAX (default 5 to 31). A value outside that range is dropped and sets `cfgErr[0]`.
- R5: Address 8 accepts ratios from 24 to 80. A value outside that range is dropped and sets `cfgErr[0]`.
- R6: A write that is in range is still dropped, and sets `cfgErr[1]`, if it would leave the slow ratio (output 8) below the largest fixed ratio or below the pending ratio of output 2 or 5. A slow ratio equal to that largest ratio is accepted.
- R7: An accepted ratio write does not change any output period until a realign command is issued.
- R8: Writing 1 to bit 0 of address 13 starts a realign. `goBusy` is high for GO_WAIT+1 cycles, starting the cycle after the write. In the cycle after `goBusy` falls, every enabled output pulses together.
- R9: Address 12 bit 0 enables output 2 and bit 1 enables output 5; both reset to 1. A cleared bit holds that output's pulse and level low from the cycle after the write. Setting the bit again resumes the output at its running phase.
- R10: On `sysClk`, an output with an even ratio r is high for r/2 cycles and low for r/2 cycles, starting with its pulse. An output with an odd ratio equals its pulse, so ratio 1 is always high.
- R11: The `cfgErr` bits stay set through later legal writes and realigns, and clear only on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock from the PLL |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 4 | Write address (1-11 ratios, 12 gate, 13 realign) |
| wrData | input | 8 | Write data |
| sysPulse | output | 11 | One-cycle enable pulse per period for each output |
| sysClk | output | 11 | Clock-style level for each output |
| goBusy | output | 1 | High while a realign is pending |
| cfgErr | output | 2 | Sticky errors: bit 0 range, bit 1 slow-ordering |

## Verification
A stale or wrong ratio register shows up as a wrong pulse interval on that output. The interval is measured within one period of the affected output, which is at most 80 source cycles. A counter that misses the restart is caught one cycle after `goBusy` falls, when the aligned pulse is absent. A mis-sequenced settle counter changes the length of `goBusy` by whole cycles. A wrong shadow or validation state shows up as a wrong error bit right after the write, or as a wrong period after the next realign.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int NUM_OUT = 11;
  localparam int RATIO_W = 8;
  localparam int ADDR_W  = 4;

  // zero-based indices of the software-programmable outputs
  localparam int IDX_SYS2 = 1;
  localparam int IDX_SYS5 = 4;
  localparam int IDX_SLOW = 7;

  localparam logic [ADDR_W-1:0] ADDR_GATE = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] ADDR_GO   = ADDR_W'(13);

  // reset / fixed ratio of each output, zero-based index
  function automatic int baseRatio(input int idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      2:       return 2;
      3:       return 3;
      4:       return 5;
      5:       return 64;
      6:       return 6;
      7:       return 64;
      8:       return 12;
      9:       return 3;
      10:      return 6;
      default: return 1;
    endcase
  endfunction

  function automatic bit isProg(input int idx);
    return (idx == IDX_SYS2) || (idx == IDX_SYS5) || (idx == IDX_SLOW);
  endfunction

  // largest ratio among the hard-wired outputs
  function automatic int fixedMax();
    int m;
    m = 0;
    for (int i = 0; i < NUM_OUT; i++)
      if (!isProg(i) && baseRatio(i) > m) m = baseRatio(i);
    return m;
  endfunction

  // control-to-datapath strobes
  typedef struct packed {
    logic               apply;
    logic [1:0]         gateOn;
    logic [RATIO_W-1:0] ratioSys2;
    logic [RATIO_W-1:0] ratioSys5;
    logic [RATIO_W-1:0] ratioSlow;
  } ctlStrobe_t;
endpackage

// File: rtl/cdb_ctrl.sv
module cdb_ctrl
  import cdb_pkg::*;
#(
  parameter int P2_MIN  = 1,
  parameter int P2_MAX  = 32,
  parameter int R5_MIN  = 5,
  parameter int R5_MAX  = 31,
  parameter int P8_MIN  = 24,
  parameter int P8_MAX  = 80,
  parameter int GO_WAIT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [RATIO_W-1:0]  wrData,
  output ctlStrobe_t          strobe,
  output logic                goBusy,
  output logic [1:0]          cfgErr
);
  localparam int WAIT_W = (GO_WAIT > 0) ? $clog2(GO_WAIT + 1) : 1;
  localparam logic [RATIO_W-1:0] LO2   = RATIO_W'(P2_MIN);
  localparam logic [RATIO_W-1:0] HI2   = RATIO_W'(P2_MAX);
  localparam logic [RATIO_W-1:0] LO5   = RATIO_W'(R5_MIN);
  localparam logic [RATIO_W-1:0] HI5   = RATIO_W'(R5_MAX);
  localparam logic [RATIO_W-1:0] LO8   = RATIO_W'(P8_MIN);
  localparam logic [RATIO_W-1:0] HI8   = RATIO_W'(P8_MAX);
  localparam logic [RATIO_W-1:0] FIXMX = RATIO_W'(fixedMax());
  localparam logic [WAIT_W-1:0]  WAIT_LOAD = WAIT_W'(GO_WAIT);

  logic [RATIO_W-1:0] shadow2, shadow5, shadowSlow;
  logic [1:0]         gateQ;
  logic               busyQ;
  logic [WAIT_W-1:0]  waitCnt;
  logic [1:0]         errQ;

  logic selSys2, selSys5, selSlow, selAny;
  logic rangeBad, orderBad, accept;
  logic goCmd;
  logic [RATIO_W-1:0] otherMax;

  assign selSys2 = wrEn && (wrAddr == ADDR_W'(IDX_SYS2 + 1));
  assign selSys5 = wrEn && (wrAddr == ADDR_W'(IDX_SYS5 + 1));
  assign selSlow = wrEn && (wrAddr == ADDR_W'(IDX_SLOW + 1));
  assign selAny  = selSys2 || selSys5 || selSlow;
  assign goCmd   = wrEn && (wrAddr == ADDR_GO) && wrData[0] && !busyQ;

  // largest ratio the slow output must not undercut
  always_comb begin
    otherMax = FIXMX;
    if (shadow2 > otherMax) otherMax = shadow2;
    if (shadow5 > otherMax) otherMax = shadow5;
  end

  always_comb begin
    rangeBad = 1'b0;
    orderBad = 1'b0;
    if (selSys2) begin
      rangeBad = (wrData < LO2) || (wrData > HI2);
      orderBad = wrData > shadowSlow;
    end else if (selSys5) begin
      rangeBad = (wrData < LO5) || (wrData > HI5);
      orderBad = wrData > shadowSlow;
    end else if (selSlow) begin
      rangeBad = (wrData < LO8) || (wrData > HI8);
      orderBad = wrData < otherMax;
    end
  end

  assign accept = selAny && !rangeBad && !orderBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow2    <= RATIO_W'(baseRatio(IDX_SYS2));
      shadow5    <= RATIO_W'(baseRatio(IDX_SYS5));
      shadowSlow <= RATIO_W'(baseRatio(IDX_SLOW));
      errQ       <= 2'b00;
    end else begin
      if (accept && selSys2) shadow2    <= wrData;
      if (accept && selSys5) shadow5    <= wrData;
      if (accept && selSlow) shadowSlow <= wrData;
      errQ[0] <= errQ[0] | (selAny && rangeBad);
      errQ[1] <= errQ[1] | (selAny && !rangeBad && orderBad);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ <= 2'b11;
    end else if (wrEn && (wrAddr == ADDR_GATE)) begin
      gateQ <= wrData[1:0];
    end
  end

  // realign sequencer: settle for GO_WAIT cycles, then one apply cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      waitCnt <= '0;
    end else if (goCmd) begin
      busyQ   <= 1'b1;
      waitCnt <= WAIT_LOAD;
    end else if (busyQ) begin
      if (waitCnt == '0) busyQ <= 1'b0;
      else               waitCnt <= waitCnt - 1'b1;
    end
  end

  assign strobe.apply     = busyQ && (waitCnt == '0);
  assign strobe.gateOn    = gateQ;
  assign strobe.ratioSys2 = shadow2;
  assign strobe.ratioSys5 = shadow5;
  assign strobe.ratioSlow = shadowSlow;
  assign goBusy = busyQ;
  assign cfgErr = errQ;
endmodule

// File: rtl/cdb_datapath.sv
module cdb_datapath
  import cdb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  output logic [NUM_OUT-1:0] pulseOut,
  output logic [NUM_OUT-1:0] levelOut
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_div
    localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(baseRatio(i));

    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] cnt;
    logic               wrap;
    logic               pulseQ, levelQ;
    logic               enable;

    if (isProg(i)) begin : g_prog
      logic [RATIO_W-1:0] loadVal;
      if (i == IDX_SYS2) begin : g_s2
        assign loadVal = strobe.ratioSys2;
      end else if (i == IDX_SYS5) begin : g_s5
        assign loadVal = strobe.ratioSys5;
      end else begin : g_sl
        assign loadVal = strobe.ratioSlow;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             ratio <= RST_RATIO;
        else if (strobe.apply) ratio <= loadVal;
      end
    end else begin : g_fixed
      assign ratio = RST_RATIO;
    end

    if (i == IDX_SYS2) begin : g_gate2
      assign enable = strobe.gateOn[0];
    end else if (i == IDX_SYS5) begin : g_gate5
      assign enable = strobe.gateOn[1];
    end else begin : g_open
      assign enable = 1'b1;
    end

    assign half = ratio >> 1;
    assign wrap = (cnt >= ratio - 1'b1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt    <= '0;
        pulseQ <= 1'b0;
        levelQ <= 1'b0;
      end else if (strobe.apply) begin
        cnt    <= '0;
        pulseQ <= 1'b0;
        levelQ <= 1'b0;
      end else begin
        cnt    <= wrap ? '0 : cnt + 1'b1;
        pulseQ <= (cnt == '0);
        levelQ <= ratio[0] ? (cnt == '0) : (cnt < half);
      end
    end

    assign pulseOut[i] = pulseQ & enable;
    assign levelOut[i] = levelQ & enable;
  end
endmodule

// File: rtl/clk_ratio_bank.sv
module clk_ratio_bank
  import cdb_pkg::*;
#(
  parameter int R5_MIN  = 5,
  parameter int R5_MAX  = 31,
  parameter int GO_WAIT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [RATIO_W-1:0] wrData,
  output logic [NUM_OUT-1:0] sysPulse,
  output logic [NUM_OUT-1:0] sysClk,
  output logic               goBusy,
  output logic [1:0]         cfgErr
);
  ctlStrobe_t strobe;

  cdb_ctrl #(
    .P2_MIN (1),
    .P2_MAX (32),
    .R5_MIN (R5_MIN),
    .R5_MAX (R5_MAX),
    .P8_MIN (24),
    .P8_MAX (80),
    .GO_WAIT(GO_WAIT)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strobe(strobe),
    .goBusy(goBusy),
    .cfgErr(cfgErr)
  );

  cdb_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pulseOut(sysPulse),
    .levelOut(sysClk)
  );
endmodule

// File: rtl/cdb_checker.sv
module cdb_checker
  import cdb_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [RATIO_W-1:0] wrData,
  input logic [NUM_OUT-1:0] sysPulse,
  input logic [NUM_OUT-1:0] sysClk,
  input logic               goBusy,
  input logic [1:0]         cfgErr
);
  function automatic logic [NUM_OUT-1:0] fixedMask();
    logic [NUM_OUT-1:0] m;
    for (int i = 0; i < NUM_OUT; i++) m[i] = !isProg(i);
    return m;
  endfunction
  localparam logic [NUM_OUT-1:0] FIX_MASK = fixedMask();

  AST_DIV2_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    sysPulse[2] |=> !sysPulse[2]);  // R1

  AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_GO && wrData[0] && !goBusy) |=> goBusy);  // R8

  AST_ALIGNED_AFTER_GO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goBusy) |=> ((sysPulse & FIX_MASK) == FIX_MASK));  // R8

  AST_GATE_STOPS_SYS2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_GATE && !wrData[0]) |=> (!sysPulse[1] && !sysClk[1]));  // R9

  AST_PULSE_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (sysPulse & ~sysClk) == '0);  // R10

  AST_RANGE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr[0] |=> cfgErr[0]);  // R11

  AST_ORDER_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr[1] |=> cfgErr[1]);  // R11
endmodule

bind clk_ratio_bank cdb_checker i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .sysPulse(sysPulse),
  .sysClk  (sysClk),
  .goBusy  (goBusy),
  .cfgErr  (cfgErr)
);

// File: tb/test_clk_ratio_bank.sv
`timescale 1ns/1ps
module test_clk_ratio_bank;
  localparam int GO_WAIT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [10:0] sysPulse, sysClk;
  logic        goBusy;
  logic [1:0]  cfgErr;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 0;

  typedef struct {
    int    idx;
    int    period;
    int    highs;
    string tag;
  } item_t;
  item_t sbq[$];

  int defRatio[11] = '{1, 3, 2, 3, 5, 64, 6, 64, 12, 3, 6};

  always #2.5 clk = ~clk;

  clk_ratio_bank #(.GO_WAIT(GO_WAIT)) i_clk_ratio_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sysPulse(sysPulse), .sysClk(sysClk), .goBusy(goBusy), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expectPeriod(input int idx, input int period, input string tag);
    item_t it;
    it.idx = idx;
    it.period = period;
    it.highs = (period == 0) ? 0 : ((period % 2 == 1) ? 1 : period / 2);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic doGo(input logic [10:0] mask, input string tag);
    int n;
    wr(13, 1);
    n = 0;
    while (goBusy && n < 50) begin
      n++;
      @(negedge clk);
    end
    check(n == GO_WAIT + 1, {tag, " busy length"}, n, GO_WAIT + 1);
    @(negedge clk);
    check(sysPulse == mask, {tag, " aligned pulses"}, int'(sysPulse), int'(mask));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(sysPulse == '0 && sysClk == '0, "R1 reset outputs", int'(sysPulse), 0);
    check(goBusy == 1'b0, "R1 reset busy", int'(goBusy), 0);
    check(cfgErr == 2'b00, "R1 reset error", int'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // monitor side of the scoreboard: measures period and high time
  initial begin
    item_t it;
    int n, hi, guard;
    bit seen;
    forever begin
      while (sbq.size() == 0) @(negedge clk);
      it = sbq[0];
      if (it.period == 0) begin
        seen = 0;
        for (int k = 0; k < 200; k++) begin
          @(negedge clk);
          if (sysPulse[it.idx] || sysClk[it.idx]) seen = 1;
        end
        check(!seen, {it.tag, " gated output stays low"}, int'(seen), 0);
      end else begin
        guard = 0;
        while (!sysPulse[it.idx] && guard < 300) begin
          @(negedge clk);
          guard++;
        end
        hi = sysClk[it.idx] ? 1 : 0;
        n = 0;
        forever begin
          @(negedge clk);
          n++;
          if (sysPulse[it.idx] || n > 200) break;
          if (sysClk[it.idx]) hi++;
        end
        check(n == it.period, $sformatf("%s period out%0d", it.tag, it.idx + 1), n, it.period);
        check(hi == it.highs, $sformatf("R10 high time out%0d (%s)", it.idx + 1, it.tag), hi, it.highs);
      end
      void'(sbq.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    doReset();

    // R1: reset ratios on every output
    for (int i = 0; i < 11; i++) expectPeriod(i, defRatio[i], "R1");
    drain();

    // R2 / R7: ignored fixed write, pending legal writes before GO
    wr(4, 7);
    wr(2, 8);
    wr(5, 10);
    wr(8, 72);
    expectPeriod(1, 3, "R7");
    expectPeriod(4, 5, "R7");
    drain();
    check(cfgErr == 2'b00, "R3 legal writes no error", int'(cfgErr), 0);
    doGo(11'h7FF, "R8");
    expectPeriod(1, 8, "R3");
    expectPeriod(4, 10, "R4");
    expectPeriod(7, 72, "R5");
    expectPeriod(3, 3, "R2");
    expectPeriod(0, 1, "R1");
    drain();

    // range violations
    wr(2, 0);
    check(cfgErr == 2'b01, "R3 zero ratio rejected", int'(cfgErr), 1);
    wr(2, 33);
    wr(5, 4);
    wr(5, 32);
    wr(8, 81);
    wr(8, 20);
    check(cfgErr == 2'b01, "R5 range error only", int'(cfgErr), 1);
    doGo(11'h7FF, "R8");
    expectPeriod(1, 8, "R3");
    expectPeriod(4, 10, "R4");
    expectPeriod(7, 72, "R5");
    drain();

    // R6: slow ordering
    wr(8, 40);
    check(cfgErr == 2'b11, "R6 ordering error", int'(cfgErr), 3);
    doGo(11'h7FF, "R8");
    expectPeriod(7, 72, "R6");
    drain();
    wr(8, 64);
    wr(2, 32);
    wr(5, 31);
    doGo(11'h7FF, "R8");
    expectPeriod(7, 64, "R6");
    expectPeriod(1, 32, "R3");
    expectPeriod(4, 31, "R4");
    drain();
    wr(2, 1);
    wr(5, 5);
    doGo(11'h7FF, "R8");
    expectPeriod(1, 1, "R10");
    expectPeriod(4, 5, "R4");
    drain();
    check(cfgErr == 2'b11, "R11 errors held", int'(cfgErr), 3);

    // R9: gating
    wr(12, 2);
    expectPeriod(1, 0, "R9");
    expectPeriod(4, 5, "R9");
    drain();
    wr(12, 1);
    expectPeriod(4, 0, "R9");
    expectPeriod(1, 1, "R9");
    drain();
    doGo(11'h7EF, "R9");
    wr(12, 3);
    expectPeriod(4, 5, "R9");
    drain();

    // R11: reset clears errors and restores defaults
    doReset();
    check(cfgErr == 2'b00, "R11 cleared by reset", int'(cfgErr), 0);
    expectPeriod(1, 3, "R11");
    expectPeriod(7, 64, "R11");
    drain();

    report();
  end
endmodule